// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block works out where an instruction's operand lives for a small 8-bit accumulator processor with a 16-bit address space. A request carries the addressing mode, the address of the opcode byte and the current X and Y index values. The sequencer then reads the operand bytes, and any pointer bytes, one at a time through a byte-wide memory read port. That port returns data one clock after the address is presented. When it finishes, it reports three things: the effective address, the program counter value that points past the operand, and the total number of clock cycles the instruction takes. The opcode fetch is counted as cycle 1.

The request side is a valid/ready stream. `req_ready` is high only while the sequencer is idle. A request is taken in a cycle in which both `req_valid` and `req_ready` are high. The requester must hold `req_valid` and the request fields steady until that happens. Once a request is accepted, the fields may change freely, because they are captured at acceptance. The result side has no back-pressure. `res_valid` is a one-cycle strobe and the consumer must take the result in that cycle. The memory read port is a plain strobe-and-address pair with a fixed one-cycle read latency.

Top module: `ea_sequencer`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle. A request is accepted on a cycle with `req_valid` and `req_ready` both high. From acceptance through the completion strobe `req_ready` stays low, and it returns high in the cycle after the strobe.
- R2: Absolute mode (code 3) reads the low address byte at PC+1 and the high byte at PC+2. The effective address is {high, low}, the result PC is PC+3 and the instruction takes 4 cycles.
- R3: Immediate mode (code 0) gives the effective address PC+1 and the result PC PC+2, and takes 2 cycles.
- R4: Zero-page mode (code 1) gives the effective address {0x00, operand}, where the operand is the byte at PC+1. The result PC is PC+2 and the instruction takes 3 cycles.
- R5: Zero-page-X mode (code 2) gives {0x00, (operand + X) mod 256}, so the high byte is always 0x00. The result PC is PC+2 and the instruction takes 4 cycles.
- R6: Absolute-Y mode (code 4) gives the 16-bit sum of {high, low} and Y, with result PC PC+3. It takes 4 cycles, or 5 when the sum's high byte differs from the base's high byte.
- R7: Indirect-X mode (code 5) forms the pointer P = (operand + X) mod 256. It reads the low byte at {0x00, P} and the high byte at {0x00, (P+1) mod 256}. The effective address is {high, low}, the result PC is PC+2 and the instruction takes 6 cycles.
- R8: Indirect-Y mode (code 6) reads a base with its low byte at {0x00, operand} and its high byte at {0x00, (operand+1) mod 256}. The effective address is base + Y, the result PC is PC+2, and the instruction takes 5 cycles, or 6 when adding Y changes the high byte.
- R9: `res_valid` is a single-cycle pulse. It is raised in cycle N counted from acceptance, where the acceptance cycle is 1 and N is the value shown on `res_cycles`. After reset, `req_ready`=1, `res_valid`=0 and `res_cycles`=0.
- R10: Mode code 7 is unassigned and behaves exactly as immediate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_mode | input | 3 | Addressing mode code (0..7) |
| req_pc | input | 16 | Address of the opcode byte |
| req_x | input | 8 | X index value |
| req_y | input | 8 | Y index value |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| res_valid | output | 1 | Completion strobe, one cycle |
| res_addr | output | 16 | Effective address |
| res_pc | output | 16 | Program counter past the operand bytes |
| res_cycles | output | 4 | Total instruction cycles |

## Verification
Two events can sit next to each other: the completion strobe of one request and the arrival of the next. During the completion cycle the requester already presents a new, differently moded request. The bench drives this back-to-back by keeping `req_valid` high and changing the fields as soon as acceptance is seen. The scoreboard then checks three things. The finishing result must still come from the old captured fields. The new request must be accepted in the cycle after the strobe, never in the strobe cycle itself. The new request's own cycle count must be measured from that later acceptance.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;

  typedef enum logic [2:0] {
    AM_IMM = 3'd0,
    AM_ZP  = 3'd1,
    AM_ZPX = 3'd2,
    AM_ABS = 3'd3,
    AM_ABY = 3'd4,
    AM_IZX = 3'd5,
    AM_IZY = 3'd6,
    AM_RSV = 3'd7
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPND,
    ST_ABSHI,
    ST_PTRLO,
    ST_PTRHI,
    ST_HOLD
  } seq_st_e;

  function automatic amode_e norm_mode(input logic [2:0] code);
    amode_e m;
    m = amode_e'(code);
    return (m == AM_RSV) ? AM_IMM : m;
  endfunction

  function automatic logic uses_x(input amode_e m);
    return (m == AM_ZPX) || (m == AM_IZX);
  endfunction

  function automatic logic uses_y(input amode_e m);
    return (m == AM_ABY) || (m == AM_IZY);
  endfunction

  function automatic logic two_byte_opnd(input amode_e m);
    return (m == AM_ABS) || (m == AM_ABY);
  endfunction

  function automatic int unsigned base_cycles(input amode_e m);
    case (m)
      AM_ZP:          return 3;
      AM_ZPX, AM_ABS,
      AM_ABY:         return 4;
      AM_IZY:         return 5;
      AM_IZX:         return 6;
      default:        return 2;
    endcase
  endfunction

endpackage

// File: rtl/ea_zp_ptr.sv
module ea_zp_ptr #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] idx,
  output logic [DW-1:0] ptr,
  output logic [DW-1:0] ptr_next
);
  // Both results stay inside page zero: the carry out of the byte is dropped.
  assign ptr      = base + idx;
  assign ptr_next = base + idx + DW'(1);
endmodule

// File: rtl/ea_idx_add.sv
module ea_idx_add #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] base,
  input  logic [DW-1:0]   idx,
  output logic [2*DW-1:0] sum,
  output logic            crossed
);
  localparam int AW = 2 * DW;

  assign sum     = base + AW'(idx);
  assign crossed = (sum[AW-1:DW] != base[AW-1:DW]);
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
  import ea_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_mode,
  input  logic [2*DW-1:0] req_pc,
  input  logic [DW-1:0]   req_x,
  input  logic [DW-1:0]   req_y,
  output logic            mem_rd,
  output logic [2*DW-1:0] mem_addr,
  input  logic [DW-1:0]   mem_rdata,
  output logic            res_valid,
  output logic [2*DW-1:0] res_addr,
  output logic [2*DW-1:0] res_pc,
  output logic [CW-1:0]   res_cycles
);
  localparam int AW = 2 * DW;
  localparam logic [DW-1:0] PAGE0 = '0;

  seq_st_e          st, nxt;
  amode_e           mode_q, md;
  logic [AW-1:0]    pc_q, npc_q, ea_q;
  logic [DW-1:0]    idx_q, lo_q, ptr_q;
  logic [CW-1:0]    cnt_q, target_q;
  logic             accept, finish;

  logic [DW-1:0]    zp_ptr, zp_unused, ptr_inc, ptr_unused;
  logic [AW-1:0]    ix_sum;
  logic             ix_cross;

  assign md        = norm_mode(req_mode);
  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign finish    = (st == ST_HOLD) && (cnt_q == target_q);

  // Page-zero pointer from the operand byte as it arrives.
  ea_zp_ptr #(.DW(DW)) u_zp (
    .base     (mem_rdata),
    .idx      (uses_x(mode_q) ? idx_q : PAGE0),
    .ptr      (zp_ptr),
    .ptr_next (zp_unused)
  );

  // Successor of the stored pointer, wrapping inside page zero.
  ea_zp_ptr #(.DW(DW)) u_zp_inc (
    .base     (ptr_q),
    .idx      (PAGE0),
    .ptr      (ptr_unused),
    .ptr_next (ptr_inc)
  );

  // Final 16-bit address: {high byte arriving now, stored low} plus Y.
  ea_idx_add #(.DW(DW)) u_ix (
    .base    ({mem_rdata, lo_q}),
    .idx     (uses_y(mode_q) ? idx_q : PAGE0),
    .sum     (ix_sum),
    .crossed (ix_cross)
  );

  always_comb begin
    nxt      = st;
    mem_rd   = 1'b0;
    mem_addr = '0;
    case (st)
      ST_IDLE: begin
        if (req_valid) begin
          mem_rd   = (md != AM_IMM);
          mem_addr = req_pc + AW'(1);
          nxt      = (md == AM_IMM) ? ST_HOLD : ST_OPND;
        end
      end
      ST_OPND: begin
        case (mode_q)
          AM_ABS, AM_ABY: begin
            mem_rd   = 1'b1;
            mem_addr = pc_q + AW'(2);
            nxt      = ST_ABSHI;
          end
          AM_IZX, AM_IZY: begin
            mem_rd   = 1'b1;
            mem_addr = {PAGE0, zp_ptr};
            nxt      = ST_PTRLO;
          end
          default: nxt = ST_HOLD;
        endcase
      end
      ST_ABSHI: nxt = ST_HOLD;
      ST_PTRLO: begin
        mem_rd   = 1'b1;
        mem_addr = {PAGE0, ptr_inc};
        nxt      = ST_PTRHI;
      end
      ST_PTRHI: nxt = ST_HOLD;
      ST_HOLD:  if (finish) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mode_q   <= AM_IMM;
      pc_q     <= '0;
      npc_q    <= '0;
      ea_q     <= '0;
      idx_q    <= '0;
      lo_q     <= '0;
      ptr_q    <= '0;
      cnt_q    <= '0;
      target_q <= '0;
    end else begin
      st <= nxt;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            mode_q <= md;
            pc_q   <= req_pc;
            idx_q  <= uses_x(md) ? req_x : (uses_y(md) ? req_y : PAGE0);
            npc_q  <= req_pc + (two_byte_opnd(md) ? AW'(3) : AW'(2));
            cnt_q  <= CW'(2);
            if (md == AM_IMM) begin
              ea_q     <= req_pc + AW'(1);
              target_q <= CW'(2);
            end
          end
        end
        ST_OPND: begin
          cnt_q <= cnt_q + CW'(1);
          lo_q  <= mem_rdata;
          ptr_q <= zp_ptr;
          if ((mode_q == AM_ZP) || (mode_q == AM_ZPX)) begin
            ea_q     <= {PAGE0, zp_ptr};
            target_q <= CW'(base_cycles(mode_q));
          end
        end
        ST_PTRLO: begin
          cnt_q <= cnt_q + CW'(1);
          lo_q  <= mem_rdata;
        end
        ST_ABSHI, ST_PTRHI: begin
          cnt_q    <= cnt_q + CW'(1);
          ea_q     <= ix_sum;
          target_q <= CW'(base_cycles(mode_q)) + CW'(ix_cross);
        end
        ST_HOLD: begin
          cnt_q <= finish ? '0 : cnt_q + CW'(1);
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  assign res_valid  = finish;
  assign res_addr   = ea_q;
  assign res_pc     = npc_q;
  assign res_cycles = target_q;

endmodule

// File: rtl/ea_seq_chk.sv
module ea_seq_chk
  import ea_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [2:0]      req_mode,
  input logic [2*DW-1:0] req_pc,
  input logic            res_valid,
  input logic [2*DW-1:0] res_addr,
  input logic [2*DW-1:0] res_pc,
  input logic [CW-1:0]   res_cycles
);
  localparam int AW = 2 * DW;

  logic          busy_c;
  logic [CW-1:0] cnt_c;
  amode_e        m_c;
  logic [AW-1:0] pc_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_c <= 1'b0;
      cnt_c  <= '0;
      m_c    <= AM_IMM;
      pc_c   <= '0;
    end else if (req_valid && req_ready) begin
      busy_c <= 1'b1;
      cnt_c  <= CW'(2);
      m_c    <= norm_mode(req_mode);
      pc_c   <= req_pc;
    end else if (res_valid) begin
      busy_c <= 1'b0;
    end else if (busy_c) begin
      cnt_c <= cnt_c + CW'(1);
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);                                             // R9
  AST_DONE_CYCLE_NUM: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (busy_c && res_cycles == cnt_c));                         // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    busy_c |-> !req_ready);                                                 // R1
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> req_ready);                                               // R1
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> req_valid);                               // R1
  AST_ABS_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (res_valid && (m_c == AM_ABS || m_c == AM_ABY)) |-> res_pc == pc_c + AW'(3)); // R2
  AST_IMM_RESULT: assert property (@(posedge clk) disable iff (rst)
    (res_valid && m_c == AM_IMM) |-> (res_addr == pc_c + AW'(1) && res_cycles == CW'(2))); // R3
  AST_ZP_PAGE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (res_valid && (m_c == AM_ZP || m_c == AM_ZPX)) |-> res_addr[AW-1:DW] == '0); // R5
  AST_ABY_CYCLES: assert property (@(posedge clk) disable iff (rst)
    (res_valid && m_c == AM_ABY) |-> (res_cycles == CW'(4) || res_cycles == CW'(5))); // R6
  AST_IZX_CYCLES: assert property (@(posedge clk) disable iff (rst)
    (res_valid && m_c == AM_IZX) |-> res_cycles == CW'(6));                 // R7
  AST_IZY_CYCLES: assert property (@(posedge clk) disable iff (rst)
    (res_valid && m_c == AM_IZY) |-> (res_cycles == CW'(5) || res_cycles == CW'(6))); // R8

endmodule

bind ea_sequencer ea_seq_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_mode   (req_mode),
  .req_pc     (req_pc),
  .res_valid  (res_valid),
  .res_addr   (res_addr),
  .res_pc     (res_pc),
  .res_cycles (res_cycles)
);

// File: tb/ea_sequencer_tb.sv
`timescale 1ns/1ps
module ea_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_mode = '0;
  logic [15:0] req_pc = '0;
  logic [7:0]  req_x = '0;
  logic [7:0]  req_y = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        res_valid;
  logic [15:0] res_addr, res_pc;
  logic [3:0]  res_cycles;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit prev_valid = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] ea;
    logic [15:0] npc;
    logic [3:0]  ncyc;
    int          acc;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] mem [int];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ea_sequencer u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_pc(req_pc), .req_x(req_x), .req_y(req_y),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_addr(res_addr), .res_pc(res_pc),
    .res_cycles(res_cycles)
  );

  function automatic logic [7:0] rd(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= rd(mem_addr);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Expected result straight from the requirements.
  task automatic calc(input logic [2:0] code, input logic [15:0] pc, input logic [7:0] x,
                      input logic [7:0] y, output exp_t e);
    logic [7:0]  op, p, lo, hi;
    logic [15:0] base;
    op = rd(pc + 16'd1);
    e.npc = pc + 16'd2;
    case ((code == 3'd7) ? 3'd0 : code)
      3'd0: begin e.ea = pc + 16'd1; e.ncyc = 2; e.tag = (code == 3'd7) ? "R10" : "R3"; end
      3'd1: begin e.ea = {8'h00, op}; e.ncyc = 3; e.tag = "R4"; end
      3'd2: begin p = op + x; e.ea = {8'h00, p}; e.ncyc = 4; e.tag = "R5"; end
      3'd3: begin e.ea = {rd(pc + 16'd2), op}; e.ncyc = 4; e.npc = pc + 16'd3; e.tag = "R2"; end
      3'd4: begin
        base = {rd(pc + 16'd2), op}; e.ea = base + {8'h00, y};
        e.ncyc = (e.ea[15:8] != base[15:8]) ? 4'd5 : 4'd4; e.npc = pc + 16'd3; e.tag = "R6";
      end
      3'd5: begin
        p = op + x; lo = rd({8'h00, p}); p = p + 8'd1; hi = rd({8'h00, p});
        e.ea = {hi, lo}; e.ncyc = 6; e.tag = "R7";
      end
      default: begin
        p = op; lo = rd({8'h00, p}); p = p + 8'd1; hi = rd({8'h00, p});
        base = {hi, lo}; e.ea = base + {8'h00, y};
        e.ncyc = (e.ea[15:8] != base[15:8]) ? 4'd6 : 4'd5; e.tag = "R8";
      end
    endcase
  endtask

  // Driver: present at a falling edge, wait for ready, push expectation.
  task automatic send(input logic [2:0] m, input logic [15:0] pc, input logic [7:0] x, input logic [7:0] y);
    exp_t e;
    req_valid = 1'b1; req_mode = m; req_pc = pc; req_x = x; req_y = y;
    while (!req_ready) @(negedge clk);
    calc(m, pc, x, y, e);
    e.acc = cyc;
    sb.push_back(e);
    @(negedge clk);
    check(req_ready == 1'b0, "R1 ready low while busy", 32'(req_ready), 32'd0);
  endtask

  task automatic drain();
    req_valid = 1'b0;
    while (sb.size() != 0 || !req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (res_valid) begin
        check(!prev_valid, "R9 strobe longer than one cycle", 32'd1, 32'd0);
        if (sb.size() == 0) begin
          check(1'b0, "R9 unexpected strobe", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(res_addr == e.ea, {e.tag, " address"}, 32'(res_addr), 32'(e.ea));
          check(res_pc == e.npc, {e.tag, " pc"}, 32'(res_pc), 32'(e.npc));
          check(res_cycles == e.ncyc, {e.tag, " cycles"}, 32'(res_cycles), 32'(e.ncyc));
          check(cyc - e.acc + 1 == int'(e.ncyc), "R9 strobe cycle", 32'(cyc - e.acc + 1), 32'(e.ncyc));
        end
      end
      prev_valid = res_valid;
    end
  end

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 reset ready", 32'(req_ready), 32'd1);
    check(res_valid == 1'b0, "R9 reset strobe", 32'(res_valid), 32'd0);
    check(res_cycles == 4'd0, "R9 reset cycles", 32'(res_cycles), 32'd0);

    send(3'd0, 16'h0000, 8'h00, 8'h00); drain();                      // R3
    mem[1] = 8'h20; send(3'd1, 16'h0000, 8'h00, 8'h00); drain();       // R4
    mem[1] = 8'h80; send(3'd2, 16'h0000, 8'hFF, 8'h00); drain();       // R5 wrap to 0x007F
    mem[16'h201] = 8'hFF; mem[16'h202] = 8'h10;
    send(3'd3, 16'h0200, 8'h00, 8'h00); drain();                       // R2 0x10FF
    mem[16'h301] = 8'h00; mem[16'h302] = 8'h10;
    send(3'd4, 16'h0300, 8'h00, 8'h01); drain();                       // R6 no cross
    send(3'd4, 16'h0200, 8'h00, 8'h01); drain();                       // R6 cross to 0x1100
    mem[16'h401] = 8'h20; mem[8'h24] = 8'h74; mem[8'h25] = 8'h20;
    send(3'd5, 16'h0400, 8'h04, 8'h00); drain();                       // R7 0x2074
    mem[16'h501] = 8'hFE; mem[8'hFF] = 8'h34; mem[8'h00] = 8'h12;
    send(3'd5, 16'h0500, 8'h01, 8'h00); drain();                       // R7 pointer wrap
    mem[16'h601] = 8'h10; mem[8'h10] = 8'h28; mem[8'h11] = 8'h10;
    send(3'd6, 16'h0600, 8'h00, 8'h10); drain();                       // R8 0x1038
    mem[8'h10] = 8'hFF;
    send(3'd6, 16'h0600, 8'h00, 8'h10); drain();                       // R8 cross 0x110F
    mem[16'h701] = 8'hFF;
    send(3'd6, 16'h0700, 8'h00, 8'h02); drain();                       // R8 pointer wrap
    send(3'd7, 16'h1234, 8'h55, 8'h66); drain();                       // R10

    // R1: back-to-back, next request waiting through the strobe cycle.
    send(3'd6, 16'h0600, 8'h00, 8'h10);
    send(3'd0, 16'hFFFF, 8'h00, 8'h00);
    send(3'd5, 16'h0400, 8'h04, 8'h00);
    send(3'd1, 16'h0000, 8'h00, 8'h00);
    drain();

    for (int i = 0; i < 40; i++) begin
      send(3'($urandom_range(0, 7)), 16'($urandom), 8'($urandom), 8'($urandom));
      if (i % 3 == 0) drain();
    end
    drain();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule